// File: doc/BRIEF.md
# UART Register Front End with Transmit and Receive FIFOs

This block is the processor-facing half of a serial port. A 32-bit word-addressed bus reaches six registers. One pushes bytes into a transmit FIFO, and one pops bytes from a receive FIFO. The other four hold the control word, the live status, the two interrupt levels and the baud setting. Both FIFOs have a parameterised depth, 64 bytes by default.

A separate frame engine does the bit shifting and the baud timing. It connects only through ports. It drains the transmit FIFO with a take strobe and reports when it is shifting. It delivers received bytes with a push strobe, together with a parity-error flag and a framing-error flag. The control word and the baud word go out to that engine unchanged.

Two interrupts follow the FIFO levels. The receive interrupt fires once enough bytes are waiting. The transmit interrupt fires once the transmit FIFO has drained far enough. Error flags stay set until software raises the clear bit. That bit has no self-clearing behaviour, so software must write it back to 0.

Top module: `uart_fe_top`

## Requirements
- R1: After reset the status word reads 0x0050_0000 (bit 20 receive-empty and bit 22 transmit-empty set, all else 0), control reads 0, both interrupts and `eng_tx_valid` are low.
- R2: Bytes written to offset 0x00 (bits 7:0) appear at `eng_tx_byte` in write order; `eng_tx_valid` is high only while control bit 12 (transmit enable) is set and the FIFO holds data, and `eng_tx_take` removes one byte only then.
- R3: A write to offset 0x00 while the transmit FIFO is full drops the byte and sets status bit 18; status bit 21 shows the FIFO full.
- R4: A byte pushed by the engine is stored only while control bit 13 (receive enable) is set and the receive FIFO is not full; reads of offset 0x04 return stored bytes in arrival order in bits 7:0, each read removing one.
- R5: A read of offset 0x04 with the receive FIFO empty returns 0 and leaves every FIFO level unchanged.
- R6: Status bit 20 is set when the receive FIFO is empty, bit 22 when the transmit FIFO is empty, and bit 25 follows `eng_tx_busy`; the transmitter is fully idle only with bit 22 set and bit 25 clear.
- R7: Status bit 16 (parity) and bit 17 (framing) latch when an engine push carries that error while receive is enabled. Control bit 24 holds bits 16, 17 and 18 at 0 for as long as it stays 1. The flags latch again once it returns to 0.
- R8: While control bit 22 is 1 the transmit FIFO is held empty, and while bit 23 is 1 the receive FIFO is held empty; bytes offered meanwhile are discarded.
- R9: `irq_rx` is high exactly when control bit 27 is set and the receive count is at least the level in bits 7:0 of offset 0x10.
- R10: `irq_tx` is high exactly when control bit 28 is set and the transmit count is at most the level in bits 15:8 of offset 0x10.
- R11: Offsets 0x08 and 0x14 read back the last full word written, 0x10 reads back bits 15:0 with upper bits 0, and `cfg_ctrl`/`cfg_baud` carry the control and baud words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Engine removes the offered byte |
| eng_tx_busy | input | 1 | Engine is shifting a frame |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_par_err | input | 1 | Delivered byte had a parity error |
| eng_rx_frm_err | input | 1 | Delivered byte had a framing error |
| cfg_ctrl | output | 32 | Control word for the engine |
| cfg_baud | output | 32 | Baud word for the engine |
| irq_rx | output | 1 | Receive level interrupt |
| irq_tx | output | 1 | Transmit level interrupt |

## Verification
The situation hardest to reach from the ports is a saturated FIFO meeting another event. One case is an overflowing write to a full transmit FIFO. Another is an engine push into a full or flushed receive FIFO while the error-clear bit is held. The bench fills the transmit FIFO to its full depth with directed writes, then drains it. This shows that the dropped byte never reaches the engine. Flush and clear windows are also driven directly. A seeded random mix of writes, takes, pushes, reads and enable changes then runs against a queue model, and it repeatedly crosses the interrupt levels.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    // word index on bus_addr[4:2]
    localparam logic [2:0] IDX_TXW  = 3'd0;
    localparam logic [2:0] IDX_RXR  = 3'd1;
    localparam logic [2:0] IDX_CTRL = 3'd2;
    localparam logic [2:0] IDX_STAT = 3'd3;
    localparam logic [2:0] IDX_LVL  = 3'd4;
    localparam logic [2:0] IDX_BAUD = 3'd5;

    // control bit positions
    localparam int C_TX_EN  = 12;
    localparam int C_RX_EN  = 13;
    localparam int C_TX_RST = 22;
    localparam int C_RX_RST = 23;
    localparam int C_CLR    = 24;
    localparam int C_RX_IE  = 27;
    localparam int C_TX_IE  = 28;

    // status bit positions
    localparam int S_PAR   = 16;
    localparam int S_FRM   = 17;
    localparam int S_WERR  = 18;
    localparam int S_RXE   = 20;
    localparam int S_TXF   = 21;
    localparam int S_TXE   = 22;
    localparam int S_BUSY  = 25;

    localparam int LVL_W = 8;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [15:0] lvl;
        logic [31:0] baud;
        logic        par_err;
        logic        frm_err;
        logic        wr_err;
    } regs_t;

endpackage

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fstate_t;

    fstate_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign count = s_q.cnt;
    assign dout  = mem_q[s_q.rptr];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push)
                s_d.wptr = (s_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wptr + 1'b1;
            if (do_pop)
                s_d.rptr = (s_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wptr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R8
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0)); // R5

endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq #(
    parameter int CNT_W = 7,
    parameter int LVL_W = 8,
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic             rx_ie,
    input  logic             tx_ie,
    output logic             irq_rx,
    output logic             irq_tx
);

    logic [CMP_W-1:0] rx_c, tx_c, rx_l, tx_l;

    always_comb begin
        rx_c   = CMP_W'(rx_cnt);
        tx_c   = CMP_W'(tx_cnt);
        rx_l   = CMP_W'(rx_lvl);
        tx_l   = CMP_W'(tx_lvl);
        irq_rx = rx_ie && (rx_c >= rx_l);
        irq_tx = tx_ie && (tx_c <= tx_l);
    end

endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int BYTE_W     = 8,
    parameter int FIFO_DEPTH = 64,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_tx_valid,
    output logic [BYTE_W-1:0] eng_tx_byte,
    input  logic              eng_tx_take,
    input  logic              eng_tx_busy,
    input  logic              eng_rx_push,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              eng_rx_par_err,
    input  logic              eng_rx_frm_err,
    output logic [DATA_W-1:0] cfg_ctrl,
    output logic [DATA_W-1:0] cfg_baud,
    output logic              irq_rx,
    output logic              irq_tx
);

    regs_t regs_d, regs_q;

    logic [2:0]       idx;
    logic             wr_acc, rd_acc, tx_push, rx_pop, rx_accept;
    logic             tx_en, rx_en, clr;
    logic [BYTE_W-1:0] tx_dout, rx_dout;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic             unused_bits;

    assign idx       = bus_addr[4:2];
    assign wr_acc    = bus_sel && bus_wr;
    assign rd_acc    = bus_sel && !bus_wr;
    assign tx_push   = wr_acc && (idx == IDX_TXW);
    assign rx_pop    = rd_acc && (idx == IDX_RXR);
    assign tx_en     = regs_q.ctrl[C_TX_EN];
    assign rx_en     = regs_q.ctrl[C_RX_EN];
    assign clr       = regs_q.ctrl[C_CLR];
    assign rx_accept = eng_rx_push && rx_en;
    assign unused_bits = ^{bus_addr[1:0], rx_full};

    uart_fe_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (regs_q.ctrl[C_TX_RST]),
        .push  (tx_push),
        .din   (bus_wdata[BYTE_W-1:0]),
        .pop   (eng_tx_take && tx_en),
        .dout  (tx_dout),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    uart_fe_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (regs_q.ctrl[C_RX_RST]),
        .push  (rx_accept),
        .din   (eng_rx_byte),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    uart_fe_irq #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_irq (
        .rx_cnt (rx_cnt),
        .tx_cnt (tx_cnt),
        .rx_lvl (regs_q.lvl[7:0]),
        .tx_lvl (regs_q.lvl[15:8]),
        .rx_ie  (regs_q.ctrl[C_RX_IE]),
        .tx_ie  (regs_q.ctrl[C_TX_IE]),
        .irq_rx (irq_rx),
        .irq_tx (irq_tx)
    );

    // next-state of the register file
    always_comb begin
        regs_d = regs_q;
        if (wr_acc) begin
            case (idx)
                IDX_CTRL: regs_d.ctrl = bus_wdata;
                IDX_LVL:  regs_d.lvl  = bus_wdata[15:0];
                IDX_BAUD: regs_d.baud = bus_wdata;
                default:  ;
            endcase
        end
        if (clr) begin
            regs_d.par_err = 1'b0;
            regs_d.frm_err = 1'b0;
            regs_d.wr_err  = 1'b0;
        end else begin
            if (rx_accept && eng_rx_par_err) regs_d.par_err = 1'b1;
            if (rx_accept && eng_rx_frm_err) regs_d.frm_err = 1'b1;
            if (tx_push && tx_full)          regs_d.wr_err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_RXR:  bus_rdata = rx_empty ? '0 : DATA_W'(rx_dout);
            IDX_CTRL: bus_rdata = regs_q.ctrl;
            IDX_STAT: begin
                bus_rdata[S_PAR]  = regs_q.par_err;
                bus_rdata[S_FRM]  = regs_q.frm_err;
                bus_rdata[S_WERR] = regs_q.wr_err;
                bus_rdata[S_RXE]  = rx_empty;
                bus_rdata[S_TXF]  = tx_full;
                bus_rdata[S_TXE]  = tx_empty;
                bus_rdata[S_BUSY] = eng_tx_busy;
            end
            IDX_LVL:  bus_rdata = DATA_W'(regs_q.lvl);
            IDX_BAUD: bus_rdata = regs_q.baud;
            default:  bus_rdata = '0;
        endcase
    end

    assign eng_tx_valid = tx_en && !tx_empty;
    assign eng_tx_byte  = tx_dout;
    assign cfg_ctrl     = regs_q.ctrl;
    assign cfg_baud     = regs_q.baud;

    AST_WERR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !clr) |=> regs_q.wr_err); // R3
    AST_ERR_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !(regs_q.par_err || regs_q.frm_err || regs_q.wr_err)); // R7
    AST_RX_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && !rx_en && !rx_pop && !regs_q.ctrl[C_RX_RST]) |=> $stable(rx_cnt)); // R4
    AST_TX_IRQ_QUIET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && (int'(regs_q.lvl[15:8]) < FIFO_DEPTH)) |-> !irq_tx); // R10

endmodule

// File: tb/uart_fe_top_tb.sv
module uart_fe_top_tb;

    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_take = 1'b0, eng_tx_busy = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_par_err = 1'b0, eng_rx_frm_err = 1'b0;
    logic [31:0] cfg_ctrl, cfg_baud;
    logic        irq_rx, irq_tx;

    always #5 clk = ~clk;

    uart_fe_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_tx_take(eng_tx_take), .eng_tx_busy(eng_tx_busy),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
        .eng_rx_par_err(eng_rx_par_err), .eng_rx_frm_err(eng_rx_frm_err),
        .cfg_ctrl(cfg_ctrl), .cfg_baud(cfg_baud), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [31:0] ctrl_m = '0;
    logic [15:0] lvl_m = '0;
    logic par_m = 0, frm_m = 0, werr_m = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[16] = par_m; s[17] = frm_m; s[18] = werr_m;
        s[20] = (rxq.size() == 0);
        s[21] = (txq.size() == D);
        s[22] = (txq.size() == 0);
        s[25] = eng_tx_busy;
        return s;
    endfunction

    function automatic logic exp_irq_rx();
        return ctrl_m[27] && (rxq.size() >= int'(lvl_m[7:0]));
    endfunction

    function automatic logic exp_irq_tx();
        return ctrl_m[28] && (txq.size() <= int'(lvl_m[15:8]));
    endfunction

    task automatic bus_write(input logic [2:0] idx, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = {idx, 2'b00}; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (idx == 3'd0) begin
            if (!ctrl_m[22]) begin
                if (txq.size() == D) begin if (!ctrl_m[24]) werr_m = 1; end
                else txq.push_back(v[7:0]);
            end
        end else if (idx == 3'd2) begin
            ctrl_m = v;
            if (v[22]) txq.delete();
            if (v[23]) rxq.delete();
            if (v[24]) begin par_m = 0; frm_m = 0; werr_m = 0; end
        end else if (idx == 3'd4) lvl_m = v[15:0];
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = {idx, 2'b00};
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        eng_rx_push = 1; eng_rx_byte = b; eng_rx_par_err = pe; eng_rx_frm_err = fe;
        @(negedge clk);
        eng_rx_push = 0; eng_rx_par_err = 0; eng_rx_frm_err = 0;
        if (ctrl_m[13]) begin
            if (!ctrl_m[23] && rxq.size() < D) rxq.push_back(b);
            if (!ctrl_m[24]) begin
                if (pe) par_m = 1;
                if (fe) frm_m = 1;
            end
        end
    endtask

    task automatic rx_read_chk();
        logic [31:0] v;
        logic [31:0] e;
        e = (rxq.size() == 0) ? 32'd0 : {24'd0, rxq[0]};
        bus_read(3'd1, v);
        chk((rxq.size() == 0) ? "R5 empty read" : "R4 rx order", v, e);
        if (rxq.size() != 0) void'(rxq.pop_front());
    endtask

    task automatic tx_take_chk();
        logic ev;
        @(negedge clk);
        #1;
        ev = ctrl_m[12] && (txq.size() != 0);
        chk("R2 tx_valid", {31'd0, eng_tx_valid}, {31'd0, ev});
        if (ev) chk("R2 tx order", {24'd0, eng_tx_byte}, {24'd0, txq[0]});
        eng_tx_take = 1;
        @(negedge clk);
        eng_tx_take = 0;
        if (ev && !ctrl_m[22]) void'(txq.pop_front());
    endtask

    task automatic status_chk(input string req);
        logic [31:0] v;
        bus_read(3'd3, v);
        chk(req, v, exp_status());
        chk("R9 irq_rx", {31'd0, irq_rx}, {31'd0, exp_irq_rx()});
        chk("R10 irq_tx", {31'd0, irq_tx}, {31'd0, exp_irq_tx()});
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_read(3'd3, v); chk("R1 status", v, 32'h0050_0000);
        bus_read(3'd2, v); chk("R1 ctrl", v, 32'd0);
        chk("R1 irqs", {30'd0, irq_rx, irq_tx}, 32'd0);
        chk("R1 tx_valid", {31'd0, eng_tx_valid}, 32'd0);

        // R11 register readback
        bus_write(3'd5, 32'hCAFE_1234);
        bus_read(3'd5, v); chk("R11 baud", v, 32'hCAFE_1234);
        chk("R11 cfg_baud", cfg_baud, 32'hCAFE_1234);
        bus_write(3'd4, 32'hFFFF_0203);
        bus_read(3'd4, v); chk("R11 level", v, 32'h0000_0203);
        bus_write(3'd2, 32'h0000_0000);
        bus_read(3'd2, v); chk("R11 ctrl", v, 32'd0);

        // R2 transmit disabled then enabled
        bus_write(3'd0, 32'h11); bus_write(3'd0, 32'h22); bus_write(3'd0, 32'h33);
        tx_take_chk();   // disabled: take ignored
        status_chk("R6 status tx data");
        bus_write(3'd2, 32'h0000_1000);
        chk("R11 cfg_ctrl", cfg_ctrl, 32'h0000_1000);
        eng_tx_busy = 1;
        status_chk("R6 busy");
        repeat (3) tx_take_chk();
        eng_tx_busy = 0;
        status_chk("R6 idle");

        // R3 overflow
        bus_write(3'd2, 32'h0000_0000);
        for (int i = 0; i < D + 1; i++) bus_write(3'd0, 32'(i + 8'h40));
        status_chk("R3 full and werr");
        bus_write(3'd2, 32'h0000_1000);
        for (int i = 0; i < D + 1; i++) tx_take_chk();
        status_chk("R3 drained");

        // R7 error latch and held clear
        bus_write(3'd2, 32'h0000_3000);
        rx_push(8'hA1, 1, 0);
        status_chk("R7 parity latched");
        bus_write(3'd2, 32'h0100_3000);
        rx_push(8'hA2, 0, 1);
        status_chk("R7 held clear");
        bus_write(3'd2, 32'h0000_3000);
        status_chk("R7 released");
        rx_push(8'hA3, 0, 1);
        status_chk("R7 frame latched");

        // R5 empty read leaves state alone
        repeat (3) rx_read_chk();
        rx_read_chk();
        status_chk("R5 status after empty read");

        // R8 flush while held
        rx_push(8'h01, 0, 0); rx_push(8'h02, 0, 0);
        bus_write(3'd0, 32'h55);
        bus_write(3'd2, 32'h00C0_3000);
        rx_push(8'h03, 0, 0);
        bus_write(3'd0, 32'h66);
        status_chk("R8 flushed");
        bus_write(3'd2, 32'h0000_3000);
        rx_read_chk();

        // R4 disabled receive drops
        bus_write(3'd2, 32'h0000_1000);
        rx_push(8'h77, 0, 0);
        rx_read_chk();

        // R9 / R10 thresholds
        bus_write(3'd4, 32'h0000_0103);
        bus_write(3'd2, 32'h1800_3000);
        status_chk("R10 tx level empty");
        rx_push(8'h10, 0, 0); rx_push(8'h11, 0, 0);
        status_chk("R9 below level");
        rx_push(8'h12, 0, 0);
        status_chk("R9 at level");
        bus_write(3'd2, 32'h1800_2000);
        bus_write(3'd0, 32'h1); bus_write(3'd0, 32'h2);
        status_chk("R10 above level");
        repeat (3) rx_read_chk();

        // random mix
        for (int it = 0; it < 2500; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1: bus_write(3'd0, 32'($urandom_range(0, 255)));
                2:    tx_take_chk();
                3, 4: rx_push(8'($urandom_range(0, 255)),
                              ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
                5, 6: rx_read_chk();
                7:    begin @(negedge clk); eng_tx_busy = $urandom_range(0, 1); end
                8:    bus_write(3'd2, {3'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                      13'd0, 1'($urandom_range(0, 3) != 0),
                                      1'($urandom_range(0, 3) != 0), 12'd0});
                default: bus_write(3'd4, {16'd0, 8'($urandom_range(0, 70)), 8'($urandom_range(0, 70))});
            endcase
            status_chk("R6 random status");
        end

        finish_run();
    end

endmodule